// File: doc/BRIEF.md
# Latched Wired-AND Bus Transceiver

This block joins a set of independent channels, three by default, each linking a local push-pull pin to one line of a shared open-drain bus. In the local-to-bus direction the value passes through a per-channel storage element. When the bus enable (active Low) is asserted, the channel pulls the bus line Low if the stored value is Low, and otherwise releases the line to the external pull-up. In the bus-to-local direction the value is passed straight through. When the local enable (active High) is asserted, the local pin is driven with the level seen on the bus.

The storage element is a clocked register. It loads on every clock edge at which its open control (active Low) is Low, and holds otherwise. When the local pin is being driven by the block, the register loads the driven level rather than the external pin value. The control that selects the loop arrangement lets the bus value reach the register through the block itself. A bus line that nobody drives, flagged by `bus_undriven`, is read as Low. Each pin is split into input, output-value and output-enable signals, so that the surrounding logic can resolve the buses.

The stored value of each channel is kept as a two-state machine. State `LS_HIGH` means the channel releases the bus and `LS_LOW` means it pulls the bus. The transition `LOAD_HIGH` is taken on an open edge with data 1, the transition `LOAD_LOW` on an open edge with data 0, and `KEEP` on every edge where the element is closed. Reset enters `LS_HIGH`. The route decoder names four modes from the two enables: `MD_QUIET` (both off), `MD_TO_BUS` (bus only), `MD_TO_LOCAL` (local only) and `MD_BOTH` (both).

Top module: `wbus_xcvr`

## Requirements
- R1: After reset every channel is in state LS_HIGH, so with the bus enable Low and the element closed, `bus_pull_low` is 0.
- R2: On a clock edge with `lat_open_n` Low and `a_en` Low, the channel stores `a_in`. While `bus_en_n` is Low, `bus_pull_low` then equals the inverse of the stored bit.
- R3: While `lat_open_n` is High, the stored bit does not change, whatever `a_in` or the bus does. With `bus_en_n` Low, `bus_pull_low` stays constant.
- R4: With `bus_en_n` High, `bus_pull_low` is 0.
- R5: `a_drive` equals `a_en`. With `a_en` High, `a_out` equals the effective bus level, which is `bus_in` AND NOT `bus_undriven`. With `a_en` Low, `a_out` is 0.
- R6: With `bus_undriven` High, the effective bus level is Low, so a driving channel outputs `a_out` = 0.
- R7: `loop_flag` is 1 exactly when `a_en` is High, `bus_en_n` is Low and `lat_open_n` is Low.
- R8: On an open edge with `a_en` High, the channel stores the effective bus level instead of `a_in`. In loop mode, a Low pulled by another agent is captured, and the line then stays Low after that agent releases it.
- R9: Each channel's storage and outputs depend only on that channel's own inputs.
- R10: When the stored bit is High and `bus_en_n` is Low, another agent may drive the line. With `a_en` High, `a_out` then follows that agent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active Low |
| a_in | input | NCH | Local pin level as seen on the pin |
| a_en | input | NCH | Local output enable, active High |
| a_out | output | NCH | Level driven onto the local pin |
| a_drive | output | NCH | Local pin driver on |
| bus_in | input | NCH | Resolved bus line level |
| bus_undriven | input | NCH | Bus line floating (no pull-up, no driver) |
| bus_en_n | input | NCH | Bus output enable, active Low |
| bus_pull_low | output | NCH | Channel pulls the bus line Low |
| lat_open_n | input | NCH | Storage open control, active Low |
| loop_flag | output | NCH | Loop arrangement selected |

## Verification
The assertions assume that `bus_in` is the AND of all agents' releases, this channel's own release included. They also assume that `bus_undriven` is raised only for a line with no pull-up. The bench builds `bus_in` from the block's own `bus_pull_low` and one modelled foreign agent per channel, so both assumptions hold throughout. Control inputs change only away from the clock edge, at the falling edge. The assertions therefore always see settled values.

// File: rtl/wbus_pkg.sv
package wbus_pkg;

    typedef enum logic {
        LS_LOW  = 1'b0,
        LS_HIGH = 1'b1
    } ls_state_e;

    typedef enum logic [1:0] {
        MD_QUIET    = 2'b00,
        MD_TO_BUS   = 2'b01,
        MD_TO_LOCAL = 2'b10,
        MD_BOTH     = 2'b11
    } route_mode_e;

endpackage

// File: rtl/wbus_store.sv
module wbus_store
    import wbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic open_n,
    input  logic d,
    output logic q
);

    ls_state_e state_q;
    ls_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= LS_HIGH;
        else
            state_q <= state_d;
    end

    // transitions: LOAD_HIGH, LOAD_LOW, KEEP
    always_comb begin
        state_d = state_q;
        if (!open_n) begin
            if (d)
                state_d = LS_HIGH;
            else
                state_d = LS_LOW;
        end
    end

    // output
    always_comb begin
        unique case (state_q)
            LS_HIGH: q = 1'b1;
            LS_LOW:  q = 1'b0;
            default: q = 1'b1;
        endcase
    end

    // R3: a closed element keeps its state
    a_r3_keep: assert property (@(posedge clk) disable iff (!rst_n)
        open_n |=> (q == $past(q)));

endmodule

// File: rtl/wbus_route.sv
module wbus_route
    import wbus_pkg::*;
(
    input  logic a_in,
    input  logic a_en,
    input  logic bus_in,
    input  logic bus_undriven,
    input  logic bus_en_n,
    input  logic lat_open_n,
    input  logic q,
    output logic a_out,
    output logic a_drive,
    output logic bus_pull_low,
    output logic latch_d,
    output logic loop_flag
);

    route_mode_e mode;
    logic        bus_eff;

    always_comb begin
        mode = route_mode_e'({a_en, ~bus_en_n});
    end

    assign bus_eff = bus_in & ~bus_undriven;

    always_comb begin
        a_out        = 1'b0;
        a_drive      = 1'b0;
        bus_pull_low = 1'b0;
        loop_flag    = 1'b0;
        unique case (mode)
            MD_QUIET: begin
            end
            MD_TO_BUS: begin
                bus_pull_low = ~q;
            end
            MD_TO_LOCAL: begin
                a_drive = 1'b1;
                a_out   = bus_eff;
            end
            MD_BOTH: begin
                a_drive      = 1'b1;
                a_out        = bus_eff;
                bus_pull_low = ~q;
                loop_flag    = ~lat_open_n;
            end
            default: begin
            end
        endcase
    end

    assign latch_d = a_drive ? a_out : a_in;

    // R6: a floating line is read Low on the local side
    always_comb begin
        a_r6_float_low: assert (!(bus_undriven && a_out));
    end

endmodule

// File: rtl/wbus_xcvr.sv
module wbus_xcvr
    import wbus_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] a_in,
    input  logic [NCH-1:0] a_en,
    output logic [NCH-1:0] a_out,
    output logic [NCH-1:0] a_drive,
    input  logic [NCH-1:0] bus_in,
    input  logic [NCH-1:0] bus_undriven,
    input  logic [NCH-1:0] bus_en_n,
    output logic [NCH-1:0] bus_pull_low,
    input  logic [NCH-1:0] lat_open_n,
    output logic [NCH-1:0] loop_flag
);

    logic [NCH-1:0] q;
    logic [NCH-1:0] latch_d;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        wbus_store u_store (
            .clk    (clk),
            .rst_n  (rst_n),
            .open_n (lat_open_n[i]),
            .d      (latch_d[i]),
            .q      (q[i])
        );

        wbus_route u_route (
            .a_in         (a_in[i]),
            .a_en         (a_en[i]),
            .bus_in       (bus_in[i]),
            .bus_undriven (bus_undriven[i]),
            .bus_en_n     (bus_en_n[i]),
            .lat_open_n   (lat_open_n[i]),
            .q            (q[i]),
            .a_out        (a_out[i]),
            .a_drive      (a_drive[i]),
            .bus_pull_low (bus_pull_low[i]),
            .latch_d      (latch_d[i]),
            .loop_flag    (loop_flag[i])
        );

        // R2: a local-only load shows up on the bus one edge later
        a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
            (!lat_open_n[i] && !a_en[i]) ##1 !bus_en_n[i]
            |-> (bus_pull_low[i] == !$past(a_in[i])));

        // R3: closed element with bus enabled keeps the bus stable
        a_r3_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
            (lat_open_n[i] && !bus_en_n[i]) ##1 !bus_en_n[i]
            |-> $stable(bus_pull_low[i]));

        // R4: bus disabled never pulls
        a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
            bus_en_n[i] |-> !bus_pull_low[i]);

        // R8: loop mode captures the effective bus level
        a_r8_loop_capture: assert property (@(posedge clk) disable iff (!rst_n)
            (loop_flag[i] && bus_undriven[i]) ##1 !bus_en_n[i]
            |-> bus_pull_low[i]);

        // R7: loop flag implies both drivers on
        a_r7_loop_drivers: assert property (@(posedge clk) disable iff (!rst_n)
            loop_flag[i] |-> (a_drive[i] && !bus_en_n[i] && !lat_open_n[i]));
    end

endmodule

// File: tb/wbus_xcvr_bench.sv
`timescale 1ns/1ps
module wbus_xcvr_bench;

    localparam int NCH = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] a_in = '0, a_en = '0, bus_undriven = '0;
    logic [NCH-1:0] bus_en_n = '1, lat_open_n = '1, other_low = '0;
    logic [NCH-1:0] a_out, a_drive, bus_pull_low, loop_flag, bus_in;
    logic [NCH-1:0] m_q;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    // wired-AND line: own release AND foreign agent release (pull-up)
    assign bus_in = ~bus_pull_low & ~other_low;

    wbus_xcvr #(.NCH(NCH)) u_wbus_xcvr (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_en(a_en), .a_out(a_out),
        .a_drive(a_drive), .bus_in(bus_in), .bus_undriven(bus_undriven),
        .bus_en_n(bus_en_n), .bus_pull_low(bus_pull_low),
        .lat_open_n(lat_open_n), .loop_flag(loop_flag)
    );

    function automatic logic exp_pull(int ch);
        return ~bus_en_n[ch] & ~m_q[ch];
    endfunction

    function automatic logic exp_beff(int ch);
        return ~bus_undriven[ch] & ~exp_pull(ch) & ~other_low[ch];
    endfunction

    // reference storage model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '1;
        else begin
            for (int ch = 0; ch < NCH; ch++)
                if (!lat_open_n[ch])
                    m_q[ch] <= a_en[ch] ? exp_beff(ch) : a_in[ch];
        end
    end

    task automatic chk(string tag, int ch, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s ch%0d: actual %b expected %b at %0t", tag, ch, act, exp, $time);
        end
    endtask

    task automatic check_all();
        for (int ch = 0; ch < NCH; ch++) begin
            chk("R5 a_drive", ch, a_drive[ch], a_en[ch]);
            chk(bus_undriven[ch] ? "R6 a_out" : "R5 a_out", ch, a_out[ch], a_en[ch] & exp_beff(ch));
            chk(bus_en_n[ch] ? "R4 pull" : "R2 pull", ch, bus_pull_low[ch], exp_pull(ch));
            chk("R7 loop", ch, loop_flag[ch], a_en[ch] & ~bus_en_n[ch] & ~lat_open_n[ch]);
        end
    endtask

    task automatic go();
        @(negedge clk);
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) go();
        rst_n = 1'b1;
        // R1: reset state releases the bus
        go(); bus_en_n = '0; #4;
        for (int ch = 0; ch < NCH; ch++) chk("R1 reset pull", ch, bus_pull_low[ch], 1'b0);
        check_all();

        // R3: load Low on ch0, then close and toggle a_in
        go(); a_in = '0; lat_open_n = 3'b110; #4; check_all();
        go(); lat_open_n = '1; #4; chk("R2 loaded low", 0, bus_pull_low[0], 1'b1);
        for (int k = 0; k < 4; k++) begin
            go(); a_in = k[0] ? '1 : '0; other_low = k[1] ? '1 : '0; #4;
            chk("R3 hold", 0, bus_pull_low[0], 1'b1);
            // R9: channels 1 and 2 untouched
            chk("R9 ch1 indep", 1, bus_pull_low[1], 1'b0);
            chk("R9 ch2 indep", 2, bus_pull_low[2], 1'b0);
        end
        go(); other_low = '0; a_in = '1; lat_open_n = 3'b110; go(); lat_open_n = '1; #4;
        chk("R2 reload high", 0, bus_pull_low[0], 1'b0);

        // R10: latch High, foreign agent drives the line to the local side
        go(); a_en = 3'b010; other_low = 3'b010; #4;
        chk("R10 follow low", 1, a_out[1], 1'b0);
        go(); other_low = '0; #4;
        chk("R10 follow high", 1, a_out[1], 1'b1);

        // R8: loop mode on ch2 captures a foreign Low and keeps it
        go(); a_en = 3'b100; lat_open_n = 3'b011; other_low = 3'b100; #4;
        chk("R7 loop flag", 2, loop_flag[2], 1'b1);
        go(); lat_open_n = '1; other_low = '0; #4;
        chk("R8 captured pull", 2, bus_pull_low[2], 1'b1);
        chk("R8 local follows", 2, a_out[2], 1'b0);
        check_all();

        // R6: floating line reads Low
        go(); a_en = '1; bus_en_n = '1; bus_undriven = '1; #4;
        for (int ch = 0; ch < NCH; ch++) chk("R6 float", ch, a_out[ch], 1'b0);
        go(); bus_undriven = '0;

        // near-exhaustive sweep of per-channel input combinations
        for (int v = 0; v < 1024; v++) begin
            go();
            for (int ch = 0; ch < NCH; ch++) begin
                int cfg;
                cfg = (v * (2 * ch + 3) + ch * 11) & 63;
                a_in[ch]         = cfg[0];
                a_en[ch]         = cfg[1];
                bus_en_n[ch]     = cfg[2];
                lat_open_n[ch]   = cfg[3];
                other_low[ch]    = cfg[4];
                bus_undriven[ch] = cfg[5];
            end
            #4;
            check_all();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule